// File: doc/BRIEF.md
# Centred 21-Tap Line Convolver

This block filters one image line at a time with a 21-tap kernel. The kernel is centred on the output sample: output n weighs the input samples from n-10 through n+10. Samples are 16-bit signed fixed point and coefficients are 18-bit signed fixed point. Where the window reaches past either end of the line, a programmable fill constant takes the place of the missing samples. The coefficients sit in an on-chip register bank, so the datapath never waits on memory and takes a new sample on every clock.

Before a pass, the host writes the kernel one tap at a time. It then streams each line in with start and end markers, and gives the length of the line and the fill constant alongside the first sample. Every line of L samples yields exactly L results, also when L is smaller than the kernel. Results carry their own start and end markers. After the last input sample the block produces the trailing results by itself, shifting in the fill constant. A separable 2-D filter uses the block twice: one pass over the rows with one coefficient set, then one pass over the columns with another.

Top module: `fir21_line_conv`

## Requirements
- R1: A line of length L accepted with `in_sol` yields exactly L results. The first result has `out_sol`=1 and the last has `out_eol`=1, and neither marker is ever high on any other result or while `out_valid` is low.
- R2: Result n equals the rounded, saturated value of the sum over taps t=0..20 of coef[t]·x[n+10−t]. Here x[i] is the i-th sample of the line, and it is the fill value captured with the line's first sample whenever i<0 or i≥L.
- R3: The raw sum has FRAC=17 fractional coefficient bits. It is rounded by adding 2^16, then shifted right arithmetically by 17. The result is clamped to the range −32768..32767.
- R4: A write with `coef_we`=1 and `coef_sel`=t stores `coef_val` into tap t. A write whose `coef_sel` is 21 or more changes no tap.
- R5: A coefficient write is discarded if it comes while a line is in progress, that is from the cycle its first sample is accepted until its last window position has been formed. The line in progress and the following lines use the taps as they were before.
- R6: With contiguous input, the results of a line come out on consecutive clocks, so `out_eol` follows `out_sol` by exactly L−1 clocks.
- R7: With contiguous input, `out_sol` is visible on the 14th falling clock edge after the falling edge at which the line's first sample is driven. This is 10 window steps plus 3 pipeline registers after the sample's rising edge.
- R8: Line lengths from 1 to 4096 are supported. Lines shorter than the kernel, including L=1, use the fill value at both ends.
- R9: After reset `out_valid` is low and every tap is zero, so a line processed before any coefficient write gives all-zero results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 5 | Tap index of the write |
| coef_val | input | 18 | Signed coefficient value |
| line_len | input | 13 | Line length, sampled with the first sample |
| fill_val | input | 16 | Boundary fill constant, sampled with the first sample |
| in_valid | input | 1 | Input sample valid |
| in_sol | input | 1 | First sample of a line |
| in_eol | input | 1 | Last sample of a line |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Result valid |
| out_sol | output | 1 | First result of a line |
| out_eol | output | 1 | Last result of a line |
| out_data | output | 16 | Signed rounded and saturated result |

## Verification
The assertions take the input stream as well formed. A line opens only when the block is idle, and only with a length between 1 and 4096. The end marker arrives exactly with sample L−1. No sample is offered while the block is flushing the tail of a line. The stimulus keeps to this: it always waits well past the flush and the pipeline before it starts the next line, and it puts idle gaps only between samples inside a line. Sweeps over every length from 1 to 48, plus the maximum length, compare each result with a sum the bench computes itself. These sweeps run with several kernels and fill values, and with saturating extremes.

// File: rtl/fir21_pkg.sv
`timescale 1ns/1ps
package fir21_pkg;
  localparam int DEF_TAPS    = 21;
  localparam int DEF_SAMP_W  = 16;
  localparam int DEF_COEF_W  = 18;
  localparam int DEF_FRAC    = 17;
  localparam int DEF_MAX_LEN = 4096;

  typedef struct packed {
    logic v;
    logic sol;
    logic eol;
  } mark_t;
endpackage

// File: rtl/fir21_coef_bank.sv
`timescale 1ns/1ps
module fir21_coef_bank #(
  parameter int TAPS   = fir21_pkg::DEF_TAPS,
  parameter int COEF_W = fir21_pkg::DEF_COEF_W,
  localparam int SELW  = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SELW-1:0]          wr_sel,
  input  logic [COEF_W-1:0]        wr_val,
  input  logic                     hold,
  output logic [TAPS*COEF_W-1:0]   coef_flat
);
  logic wr_ok;
  assign wr_ok = wr_en && !hold && (int'(wr_sel) < TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef_flat <= '0;
    else if (wr_ok) coef_flat[int'(wr_sel)*COEF_W +: COEF_W] <= wr_val;
  end

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold) |=> $stable(coef_flat)); // R5
endmodule

// File: rtl/fir21_window.sv
`timescale 1ns/1ps
module fir21_window #(
  parameter int TAPS    = fir21_pkg::DEF_TAPS,
  parameter int SAMP_W  = fir21_pkg::DEF_SAMP_W,
  parameter int MAX_LEN = fir21_pkg::DEF_MAX_LEN,
  localparam int HALF   = (TAPS - 1) / 2,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int KW     = $clog2(MAX_LEN + HALF + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LW-1:0]            line_len,
  input  logic [SAMP_W-1:0]        fill_val,
  input  logic                     in_valid,
  input  logic                     in_sol,
  input  logic                     in_eol,
  input  logic [SAMP_W-1:0]        in_data,
  output logic                     line_busy,
  output logic [TAPS*SAMP_W-1:0]   win_flat,
  output fir21_pkg::mark_t         win_mark
);
  logic              busy, rx_done;
  logic [KW-1:0]     k;
  logic [LW-1:0]     len_q;
  logic [SAMP_W-1:0] fill_q;

  // named events
  logic          start, feed, flush, step;
  logic [KW-1:0] k_next, len_m1, last_k;
  logic [SAMP_W-1:0] shift_val;

  assign start     = in_valid && in_sol && !busy;
  assign feed      = busy && !rx_done && in_valid;
  assign flush     = busy && rx_done;
  assign step      = feed || flush;
  assign k_next    = k + KW'(1);
  assign len_m1    = KW'(len_q) - KW'(1);
  assign last_k    = KW'(len_q) + KW'(HALF - 1);
  assign shift_val = feed ? in_data : fill_q;
  assign line_busy = busy || (in_valid && in_sol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rx_done  <= 1'b0;
      k        <= '0;
      len_q    <= '0;
      fill_q   <= '0;
      win_flat <= '0;
      win_mark <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      rx_done  <= (line_len == LW'(1));
      k        <= '0;
      len_q    <= line_len;
      fill_q   <= fill_val;
      win_flat <= {{(TAPS-1){fill_val}}, in_data};
      win_mark <= '0;
    end else if (step) begin
      win_flat <= {win_flat[(TAPS-1)*SAMP_W-1:0], shift_val};
      k        <= k_next;
      if (feed && k_next == len_m1) rx_done <= 1'b1;
      if (flush && k_next == last_k) busy <= 1'b0;
      win_mark.v   <= (k_next >= KW'(HALF));
      win_mark.sol <= (k_next == KW'(HALF));
      win_mark.eol <= (k_next == last_k);
    end else begin
      win_mark <= '0;
    end
  end

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (line_len != '0 && int'(line_len) <= MAX_LEN)); // R8
  AST_NO_FEED_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_valid); // R6
  AST_EOL_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    feed |-> (in_eol == (k_next == len_m1))); // R1
  AST_EDGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (win_flat[(TAPS-1)*SAMP_W +: SAMP_W] == $past(fill_val))); // R2
endmodule

// File: rtl/fir21_mac.sv
`timescale 1ns/1ps
module fir21_mac #(
  parameter int TAPS   = fir21_pkg::DEF_TAPS,
  parameter int SAMP_W = fir21_pkg::DEF_SAMP_W,
  parameter int COEF_W = fir21_pkg::DEF_COEF_W,
  parameter int FRAC   = fir21_pkg::DEF_FRAC,
  localparam int PW    = SAMP_W + COEF_W,
  localparam int AW    = PW + $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TAPS*SAMP_W-1:0]   win_flat,
  input  logic [TAPS*COEF_W-1:0]   coef_flat,
  input  fir21_pkg::mark_t         mark_in,
  output fir21_pkg::mark_t         mark_out,
  output logic [SAMP_W-1:0]        y
);
  localparam logic signed [AW-1:0] RND  = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) << (SAMP_W - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  function automatic logic [SAMP_W-1:0] round_sat(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] r;
    r = (a + RND) >>> FRAC;
    if (r > MAXV)      r = MAXV;
    else if (r < MINV) r = MINV;
    return r[SAMP_W-1:0];
  endfunction

  logic signed [PW-1:0] prod [TAPS];
  logic signed [AW-1:0] acc_d, acc_q;
  fir21_pkg::mark_t     m1, m2;

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      prod[t] <= $signed(win_flat[t*SAMP_W +: SAMP_W]) * $signed(coef_flat[t*COEF_W +: COEF_W]);
    end
  end

  always_comb begin
    acc_d = '0;
    for (int t = 0; t < TAPS; t++) acc_d = acc_d + AW'(prod[t]);
  end

  always_ff @(posedge clk) begin
    acc_q <= acc_d;
    y     <= round_sat(acc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; mark_out <= '0;
    end else begin
      m1 <= mark_in; m2 <= m1; mark_out <= m2;
    end
  end

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (m2.v && acc_q + RND > (MAXV <<< FRAC) + (RND <<< 1)) |=> (y == MAXV[SAMP_W-1:0])); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (m2.v && acc_q < (MINV <<< FRAC) - (RND <<< 1)) |=> (y == MINV[SAMP_W-1:0])); // R3
endmodule

// File: rtl/fir21_line_conv.sv
`timescale 1ns/1ps
module fir21_line_conv #(
  parameter int TAPS    = fir21_pkg::DEF_TAPS,
  parameter int SAMP_W  = fir21_pkg::DEF_SAMP_W,
  parameter int COEF_W  = fir21_pkg::DEF_COEF_W,
  parameter int FRAC    = fir21_pkg::DEF_FRAC,
  parameter int MAX_LEN = fir21_pkg::DEF_MAX_LEN
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          coef_we,
  input  logic [$clog2(TAPS)-1:0]       coef_sel,
  input  logic [COEF_W-1:0]             coef_val,
  input  logic [$clog2(MAX_LEN+1)-1:0]  line_len,
  input  logic [SAMP_W-1:0]             fill_val,
  input  logic                          in_valid,
  input  logic                          in_sol,
  input  logic                          in_eol,
  input  logic [SAMP_W-1:0]             in_data,
  output logic                          out_valid,
  output logic                          out_sol,
  output logic                          out_eol,
  output logic [SAMP_W-1:0]             out_data
);
  logic                   line_busy;
  logic [TAPS*SAMP_W-1:0] win_flat;
  logic [TAPS*COEF_W-1:0] coef_flat;
  fir21_pkg::mark_t       win_mark, res_mark;

  fir21_coef_bank #(.TAPS(TAPS), .COEF_W(COEF_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_sel(coef_sel),
    .wr_val(coef_val), .hold(line_busy), .coef_flat(coef_flat));

  fir21_window #(.TAPS(TAPS), .SAMP_W(SAMP_W), .MAX_LEN(MAX_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .line_len(line_len), .fill_val(fill_val),
    .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol), .in_data(in_data),
    .line_busy(line_busy), .win_flat(win_flat), .win_mark(win_mark));

  fir21_mac #(.TAPS(TAPS), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_mac (
    .clk(clk), .rst_n(rst_n), .win_flat(win_flat), .coef_flat(coef_flat),
    .mark_in(win_mark), .mark_out(res_mark), .y(out_data));

  assign out_valid = res_mark.v;
  assign out_sol   = res_mark.sol;
  assign out_eol   = res_mark.eol;

  // tracks whether a result line is open at the output
  logic out_open;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_open <= 1'b0;
    else if (out_valid) begin
      if (out_eol)      out_open <= 1'b0;
      else if (out_sol) out_open <= 1'b1;
    end
  end

  AST_MARK_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_sol && !out_eol)); // R1
  AST_SOL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sol) |-> !out_open); // R1
  AST_BODY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sol) |-> out_open); // R1
endmodule

// File: tb/sim_fir21_line_conv.sv
`timescale 1ns/1ps
module sim_fir21_line_conv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_we = 1'b0;
  logic [4:0] coef_sel = '0;
  logic [17:0] coef_val = '0;
  logic [12:0] line_len = '0;
  logic [15:0] fill_val = '0;
  logic in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [15:0] in_data = '0;
  logic out_valid, out_sol, out_eol;
  logic [15:0] out_data;

  fir21_line_conv u0 (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_val(coef_val), .line_len(line_len), .fill_val(fill_val),
    .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol), .in_data(in_data),
    .out_valid(out_valid), .out_sol(out_sol), .out_eol(out_eol), .out_data(out_data));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int cm [21];
  int xs [4096];
  int ex [4096];
  int got [4200];
  bit gs [4200];
  bit ge [4200];
  int got_n = 0;
  int sol_cyc = 0, eol_cyc = 0, t_in = 0;

  always @(negedge clk) begin
    if (out_valid && got_n < 4200) begin
      got[got_n] = int'($signed(out_data));
      gs[got_n] = out_sol;
      ge[got_n] = out_eol;
      if (out_sol) sol_cyc = cyc;
      if (out_eol) eol_cyc = cyc;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_out(input int n, input int len, input int fv);
    longint acc = 0;
    longint q;
    for (int t = 0; t < 21; t++) begin
      int i = n + 10 - t;
      longint x = (i < 0 || i >= len) ? longint'(fv) : longint'(xs[i]);
      acc += x * longint'(cm[t]);
    end
    q = (acc + 64'sd65536) >>> 17;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic load_coef(input int sel, input int val, input bit apply);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = 5'(sel); coef_val = 18'(val);
    @(negedge clk);
    coef_we = 1'b0;
    if (apply && sel < 21) cm[sel] = val;
  endtask

  // mode 0: hashed samples, mode 1: every sample equals the fill value
  task automatic run_line(input int len, input int fv, input int seed, input int mode,
                          input bit gaps, input string req);
    logic signed [15:0] h;
    bit mk_ok = 1'b1;
    for (int i = 0; i < len; i++) begin
      h = 16'((i * 40503 + seed * 9973) ^ (i >> 2));
      xs[i] = (mode == 1) ? fv : int'(h);
    end
    for (int n = 0; n < len; n++) ex[n] = ref_out(n, len, fv);
    got_n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 16'(xs[i]);
      in_sol = (i == 0); in_eol = (i == len - 1);
      line_len = 13'(len); fill_val = 16'(fv);
      if (i == 0) t_in = cyc;
      if (gaps && (i % 3 == 1) && i != len - 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    repeat (40) @(negedge clk);
    chk(got_n == len, "R1", $sformatf("result count len=%0d", len), got_n, len);
    for (int n = 0; n < len && n < got_n; n++)
      chk(got[n] == ex[n], req, $sformatf("value len=%0d n=%0d", len, n), got[n], ex[n]);
    for (int n = 0; n < got_n; n++)
      if (gs[n] != (n == 0) || ge[n] != (n == len - 1)) mk_ok = 1'b0;
    chk(mk_ok, "R1", $sformatf("markers len=%0d", len), mk_ok, 1);
    if (!gaps) begin
      chk(sol_cyc - t_in == 14, "R7", $sformatf("first result delay len=%0d", len), sol_cyc - t_in, 14);
      chk(eol_cyc - sol_cyc == len - 1, "R6", $sformatf("result span len=%0d", len), eol_cyc - sol_cyc, len - 1);
    end
  endtask

  task automatic load_set(input int seed);
    for (int t = 0; t < 21; t++) begin
      int v = ((t * 7919 + seed * 104729) % 80001) - 40000;
      load_coef(t, v, 1'b1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 21; t++) cm[t] = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    run_line(25, 1234, 1, 0, 1'b0, "R9");

    // half-scale centre tap: rounding of x/2
    load_coef(10, 65536, 1'b1);
    run_line(30, -3, 2, 0, 1'b0, "R3");

    // single taps at both window ends show the offset direction
    load_coef(10, 0, 1'b1);
    load_coef(0, 131071, 1'b1);
    run_line(33, 777, 3, 0, 1'b0, "R2");
    load_coef(0, 0, 1'b1);
    load_coef(20, -131072, 1'b1);
    run_line(33, -500, 4, 0, 1'b0, "R2");

    // full kernel, length sweep including lines shorter than the kernel
    load_set(5);
    for (int len = 1; len <= 48; len++)
      run_line(len, (len * 311) - 7000, len, 0, 1'b0, "R8");
    run_line(37, 4321, 9, 0, 1'b1, "R2");
    run_line(4096, -12345, 11, 0, 1'b0, "R8");

    // out-of-range tap indices leave the kernel untouched
    for (int s = 21; s < 32; s++) load_coef(s, 99999, 1'b1);
    run_line(27, 100, 12, 0, 1'b0, "R4");

    // write during a line is discarded
    fork
      run_line(40, 2000, 13, 0, 1'b0, "R5");
      begin
        repeat (6) @(negedge clk);
        load_coef(3, -77777, 1'b0);
      end
    join
    run_line(24, -2000, 14, 0, 1'b0, "R5");

    // saturation at both rails
    for (int t = 0; t < 21; t++) load_coef(t, 131071, 1'b1);
    run_line(15, 32767, 15, 1, 1'b0, "R3");
    run_line(15, -32768, 16, 1, 1'b0, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule